// File: doc/BRIEF.md
# Programmable FIFO Trigger and Ready Status

This block sits beside the FIFOs of a four-channel UART and decides, per channel, when the receive side has collected enough characters and when the transmit side has opened enough free space. Each of these two conditions drives a bit in one packed 8-bit status word and a per-channel request line. The request line serves as an interrupt or DMA request.

Each channel owns an 8-bit trigger register. The upper nibble sets the receive threshold and the lower nibble sets the transmit threshold, each as four times the nibble value. A nibble of zero hands that direction back to a 2-bit legacy selector supplied from the FIFO-control logic. The register is written through a simple write port, and only while two unlock qualifiers are both high. The status word is computed combinationally from the live counts, so software or a DMA engine sees the FIFO state with no added delay.

Top module: `fifo_trig_status`

## Requirements
- R1: After reset every trigger register holds 0x00, so both directions of every channel use their legacy selector level.
- R2: A nonzero upper nibble N (bits [7:4]) of a channel's trigger register sets its receive threshold to 4*N characters. The RX ready flag is 1 when the fill count is at least that value.
- R3: A nonzero lower nibble N (bits [3:0]) sets the transmit threshold to 4*N free spaces. The TX ready flag is 1 when the free count is at least that value.
- R4: With a zero upper nibble, the receive selector codes 0,1,2,3 give thresholds of 8, 16, 56 and 60 characters.
- R5: With a zero lower nibble, the transmit selector codes 0,1,2,3 give thresholds of 8, 16, 32 and 56 spaces.
- R6: A write updates the register of channel `wr_chan` on the clock edge only when `wr_en`, `unlock_a` and `unlock_b` are all 1. In every other case the register keeps its value.
- R7: Status bit 4+i is the RX ready flag of channel i, and status bit i is the TX ready flag of channel i.
- R8: An active `rx_timeout[i]` forces the RX ready flag of channel i to 1, whatever the fill count.
- R9: The status word follows count changes in the same cycle, with no register in the path.
- R10: `rx_req[i]` equals RX ready of channel i ANDed with `rx_req_en[i]`. `tx_req[i]` equals TX ready ANDed with `tx_req_en[i]`.
- R11: A count of 64 meets every threshold, including the largest programmed level of 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Trigger register write strobe |
| wr_chan | input | 2 | Channel selected for the write |
| wr_data | input | 8 | Write data: [7:4] RX nibble, [3:0] TX nibble |
| unlock_a | input | 1 | First write qualifier (enhanced-function enable) |
| unlock_b | input | 1 | Second write qualifier (modem-control enable) |
| rx_sel | input | 8 | Legacy RX selector, 2 bits per channel, channel i at [2i+1:2i] |
| tx_sel | input | 8 | Legacy TX selector, 2 bits per channel, channel i at [2i+1:2i] |
| rx_fill | input | 28 | RX fill count, 7 bits per channel, channel i at [7i+6:7i] |
| tx_free | input | 28 | TX free count, 7 bits per channel, channel i at [7i+6:7i] |
| rx_timeout | input | 4 | RX timeout flag per channel |
| rx_req_en | input | 4 | RX request enable per channel |
| tx_req_en | input | 4 | TX request enable per channel |
| status | output | 8 | Packed ready word: [7:4] RX, [3:0] TX |
| rx_req | output | 4 | RX interrupt/DMA request per channel |
| tx_req | output | 4 | TX interrupt/DMA request per channel |

## Verification
Each threshold is probed one count below and exactly at its value, so a comparison of the wrong strictness shows up as a flag that turns on one count late or early. Every legacy code is exercised in both directions, which catches a swapped or shifted mapping table. A write is tried with each unlock qualifier missing and then observed through a count that only the new level would satisfy, so a loose gate shows up as a spuriously set flag. Timeout with an empty FIFO, a full count of 64 against a level of 60, and enable gating on the request lines close off the remaining corners. A design with a reversed bit packing would set the wrong status bit in these tests.

// File: rtl/fifo_trig_status.sv
module fifo_trig_status #(
  parameter int NCH = 4,
  parameter int CW  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NCH)-1:0]  wr_chan,
  input  logic [7:0]              wr_data,
  input  logic                    unlock_a,
  input  logic                    unlock_b,
  input  logic [2*NCH-1:0]        rx_sel,
  input  logic [2*NCH-1:0]        tx_sel,
  input  logic [CW*NCH-1:0]       rx_fill,
  input  logic [CW*NCH-1:0]       tx_free,
  input  logic [NCH-1:0]          rx_timeout,
  input  logic [NCH-1:0]          rx_req_en,
  input  logic [NCH-1:0]          tx_req_en,
  output logic [2*NCH-1:0]        status,
  output logic [NCH-1:0]          rx_req,
  output logic [NCH-1:0]          tx_req
);
  localparam int RW = 8*NCH;

  logic [RW-1:0]  trig_q;
  logic [NCH-1:0] rx_rdy, tx_rdy;
  logic           wr_ok;

  assign wr_ok = wr_en && unlock_a && unlock_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     trig_q <= '0;
    else if (wr_ok) trig_q[wr_chan*8 +: 8] <= wr_data;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [3:0]    rx_nib, tx_nib;
    logic [CW-1:0] rx_lvl, tx_lvl, rx_leg, tx_leg;

    assign rx_nib = trig_q[i*8+4 +: 4];
    assign tx_nib = trig_q[i*8   +: 4];

    always_comb begin
      case (rx_sel[2*i +: 2])
        2'd0:    rx_leg = CW'(8);
        2'd1:    rx_leg = CW'(16);
        2'd2:    rx_leg = CW'(56);
        default: rx_leg = CW'(60);
      endcase
      case (tx_sel[2*i +: 2])
        2'd0:    tx_leg = CW'(8);
        2'd1:    tx_leg = CW'(16);
        2'd2:    tx_leg = CW'(32);
        default: tx_leg = CW'(56);
      endcase
    end

    assign rx_lvl = (rx_nib == 4'd0) ? rx_leg : CW'({rx_nib, 2'b00});
    assign tx_lvl = (tx_nib == 4'd0) ? tx_leg : CW'({tx_nib, 2'b00});

    assign rx_rdy[i] = rx_timeout[i] || (rx_fill[i*CW +: CW] >= rx_lvl);
    assign tx_rdy[i] = tx_free[i*CW +: CW] >= tx_lvl;

    p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_timeout[i] |-> status[NCH+i]);

    p_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fill[i*CW +: CW] == CW'(64)) |-> status[NCH+i]);

    p_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_req[i] == (status[NCH+i] && rx_req_en[i])) &&
      (tx_req[i] == (status[i] && tx_req_en[i])));

    p_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && wr_chan == i) |=> trig_q[i*8 +: 8] == $past(wr_data));
  end

  assign status = {rx_rdy, tx_rdy};
  assign rx_req = rx_rdy & rx_req_en;
  assign tx_req = tx_rdy & tx_req_en;

  p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(trig_q));

endmodule

// File: tb/fifo_trig_status_tb.sv
module fifo_trig_status_tb;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, unlock_a = 0, unlock_b = 0;
  logic [1:0]  wr_chan = 0;
  logic [7:0]  wr_data = 0;
  logic [7:0]  rx_sel = 0, tx_sel = 0;
  logic [27:0] rx_fill = 0, tx_free = 0;
  logic [3:0]  rx_timeout = 0, rx_req_en = 0, tx_req_en = 0;
  logic [7:0]  status;
  logic [3:0]  rx_req, tx_req;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fifo_trig_status u_dut (.*);

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_rx(input int ch, input int v);
    @(negedge clk); rx_fill[ch*7 +: 7] = 7'(v); #1;
  endtask

  task automatic set_tx(input int ch, input int v);
    @(negedge clk); tx_free[ch*7 +: 7] = 7'(v); #1;
  endtask

  task automatic wr(input int ch, input logic [7:0] d, input logic a, input logic b);
    @(negedge clk);
    wr_en = 1; wr_chan = 2'(ch); wr_data = d; unlock_a = a; unlock_b = b;
    @(negedge clk);
    wr_en = 0; unlock_a = 0; unlock_b = 0;
  endtask

  task automatic t_reset;
    chk(status == 8'h00, 1'b1, "R1 status zero after reset");
    set_rx(0, 7); chk(status[4], 0, "R1 R4 ch0 rx 7 < 8");
    set_rx(0, 8); chk(status[4], 1, "R1 R4 ch0 rx 8 >= 8");
    set_tx(0, 8); chk(status[0], 1, "R1 R5 ch0 tx 8 >= 8");
    set_rx(0, 0); set_tx(0, 0);
  endtask

  task automatic t_legacy_rx;
    rx_sel[2 +: 2] = 2'd1;
    set_rx(1, 15); chk(status[5], 0, "R4 sel1 15");
    set_rx(1, 16); chk(status[5], 1, "R4 sel1 16");
    rx_sel[2 +: 2] = 2'd2;
    set_rx(1, 55); chk(status[5], 0, "R4 sel2 55");
    set_rx(1, 56); chk(status[5], 1, "R4 sel2 56");
    rx_sel[2 +: 2] = 2'd3;
    set_rx(1, 59); chk(status[5], 0, "R4 sel3 59");
    set_rx(1, 60); chk(status[5], 1, "R4 sel3 60");
    set_rx(1, 0); rx_sel = 0;
  endtask

  task automatic t_legacy_tx;
    tx_sel[6 +: 2] = 2'd1;
    set_tx(3, 15); chk(status[3], 0, "R5 sel1 15");
    set_tx(3, 16); chk(status[3], 1, "R5 sel1 16");
    tx_sel[6 +: 2] = 2'd2;
    set_tx(3, 31); chk(status[3], 0, "R5 sel2 31");
    set_tx(3, 32); chk(status[3], 1, "R5 sel2 32");
    tx_sel[6 +: 2] = 2'd3;
    set_tx(3, 55); chk(status[3], 0, "R5 sel3 55");
    set_tx(3, 56); chk(status[3], 1, "R5 sel3 56");
    chk(status[7], 0, "R7 tx ch3 leaves rx ch3 bit");
    set_tx(3, 0); tx_sel = 0;
  endtask

  task automatic t_prog;
    wr(2, 8'h53, 1, 1);
    set_rx(2, 19); chk(status[6], 0, "R2 ch2 rx 19 < 20");
    set_rx(2, 20); chk(status[6], 1, "R2 ch2 rx 20");
    chk(status == 8'h40, 1'b1, "R7 only bit6 set");
    set_tx(2, 11); chk(status[2], 0, "R3 ch2 tx 11 < 12");
    set_tx(2, 12); chk(status[2], 1, "R3 ch2 tx 12");
    set_rx(2, 0); set_tx(2, 0);
  endtask

  task automatic t_locked;
    wr(1, 8'h11, 1, 0);
    wr(1, 8'h11, 0, 1);
    set_rx(1, 4); chk(status[5], 0, "R6 locked write ignored rx");
    set_tx(1, 4); chk(status[1], 0, "R6 locked write ignored tx");
    set_rx(1, 0); set_tx(1, 0);
  endtask

  task automatic t_timeout;
    @(negedge clk); rx_timeout = 4'b1000; #1;
    chk(status[7], 1, "R8 timeout ch3 with empty fifo");
    chk(status[6:4] == 3'b000, 1'b1, "R8 other channels unaffected");
    @(negedge clk); rx_timeout = 0; #1;
    chk(status[7], 0, "R8 timeout released");
  endtask

  task automatic t_full;
    wr(0, 8'hFF, 1, 1);
    set_rx(0, 59); chk(status[4], 0, "R11 59 < 60");
    set_rx(0, 64); chk(status[4], 1, "R11 rx 64 meets 60");
    set_tx(0, 64); chk(status[0], 1, "R11 tx 64 meets 60");
  endtask

  task automatic t_req;
    @(negedge clk); rx_req_en = 4'b0000; tx_req_en = 4'b0000; #1;
    chk(rx_req[0], 0, "R10 rx req disabled");
    chk(tx_req[0], 0, "R10 tx req disabled");
    @(negedge clk); rx_req_en = 4'b0001; tx_req_en = 4'b0001; #1;
    chk(rx_req[0], 1, "R10 rx req enabled");
    chk(tx_req[0], 1, "R10 tx req enabled");
    chk(rx_req[1], 0, "R10 ch1 rx req no ready");
  endtask

  task automatic t_realtime;
    @(posedge clk); #1;
    rx_fill[0 +: 7] = 7'd10; #0.5;
    chk(status[4], 0, "R9 drops without clock edge");
    rx_fill[0 +: 7] = 7'd60; #0.5;
    chk(status[4], 1, "R9 rises without clock edge");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    t_reset;
    t_legacy_rx;
    t_legacy_tx;
    t_prog;
    t_locked;
    t_timeout;
    t_full;
    t_req;
    t_realtime;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule